// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block controls how a processor core enters and leaves a low-power state in which its clock is stopped. The decoder raises a stop request when it recognises a stop instruction. The sequencer then runs the execute cycle and blocks decode of the instruction already fetched behind it. After that it parks in stop cycle 4 with the core and peripheral clock enable held low. It stays there for as long as no wake event arrives.

Three active-low asynchronous lines can end the stop state: an interrupt request, a reset request and a debug request. The sequencer synchronises each one. When any of them is seen low, it starts a clock-stabilisation count. A select bit sets the length of that count: a long count for a crystal oscillator that is still settling, or a short count for a clean external clock.

When the count ends, the clock enable returns and cycle 4 completes. In that cycle the interrupt request line is sampled a second time. The request is reported as pending only if the line is still low at that point. Cycles 5 to 8 then run, and the sequencer signals whether execution resumes at the instruction after the stop instruction. A reset wake skips that path and instead asks for the reset sequence.

Top module: `stop_wake_seq`

## Requirements
- R1: A low level on any of `irq_ni`, `rst_wake_ni` or `dbg_ni` ends the wait in stop cycle 4. Each line goes through a two-flop synchronizer, so a line that is low at clock edge k starts the delay count at edge k+2. With no wake, the block stays in cycle 4 for any length of time.
- R2: A stop request accepted while running gives one cycle with `stop_cyc_o`=3, `decode_block_o`=1 and `clk_en_o`=1. The next cycle is cycle 4 with `clk_en_o`=0. A stop request made while a stop sequence is in progress has no effect.
- R3: The delay lasts 131072 clocks when `short_dly_i`=0 and 16 clocks when it is 1. The select bit is captured when the count loads, so a later change of the bit does not alter the length of the running count.
- R4: `clk_en_o` is 0 from the start of cycle 4 until the delay ends. If a wake line is low at edge k, `clk_en_o` is 1 again after edge k+2+L, where L is the delay length.
- R5: In the completing cycle of stop cycle 4, `irq_pend_o` pulses for one cycle if `irq_ni` was low at edge k+L. This applies whichever line caused the wake. If `irq_ni` was high at that edge, there is no pulse.
- R6: After the delay, cycle 4 lasts one more clock, then cycles 5, 6, 7 and 8 last four clocks each, 17 clocks in all. The block then returns to running.
- R7: In the first running cycle after cycle 8, `resume_o` pulses for one cycle when no interrupt was flagged pending. It stays 0 when an interrupt was flagged pending.
- R8: A reset wake takes priority over the other lines. When its delay ends, the block goes straight to running and pulses `rst_seq_o` for one cycle. In that case there is no tail, no `irq_pend_o` pulse and no `resume_o` pulse.
- R9: `stop_cyc_o` reads 0 while running and 3 to 8 during a stop sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock (one T per cycle) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_i | input | 1 | Stop instruction decoded (stop cycle 2) |
| irq_ni | input | 1 | Interrupt request wake line, active low, asynchronous |
| rst_wake_ni | input | 1 | Reset wake line, active low, asynchronous |
| dbg_ni | input | 1 | Debug request wake line, active low, asynchronous |
| short_dly_i | input | 1 | Delay select: 0 long, 1 short |
| clk_en_o | output | 1 | Core and peripheral clock enable |
| stop_cyc_o | output | 4 | Current stop cycle, 0 while running |
| decode_block_o | output | 1 | Blocks decode of the instruction fetched after stop |
| irq_pend_o | output | 1 | Interrupt request flagged pending at end of delay |
| resume_o | output | 1 | Resume at the instruction after stop |
| rst_seq_o | output | 1 | Reset wake: start the reset sequence |

## Verification
The bench releases the interrupt line exactly at the last edge that should drop it (clock L) and one edge later. A design that samples the line early, late or while the count is still running gets the pending flag wrong in one of the two runs. It also combines a reset wake with an interrupt line that is held low. A design that lacks the reset priority would run the tail and raise pending or resume instead of the reset request. The delay select is flipped part way through each count, which catches a count that keeps tracking the live bit. Every clock of cycle 4 and of the tail is checked, so an off-by-one in the 17-clock tail or in the enable timing appears as a wrong cycle number.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [2:0] {
    PH_RUN,
    PH_EXEC,
    PH_WAIT,
    PH_CNT,
    PH_TAIL
  } phase_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_RST,
    SRC_IRQ,
    SRC_DBG
  } src_e;

  localparam int unsigned WAKE_N   = 3;
  localparam int unsigned W_RST    = 0;
  localparam int unsigned W_IRQ    = 1;
  localparam int unsigned W_DBG    = 2;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_ni,
  output logic [N-1:0] sync_no
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= pins_ni[g];
        s2_q <= s1_q;
      end
    end
    assign sync_no[g] = s2_q;
  end
endmodule

// File: rtl/stop_dly_cnt.sv
module stop_dly_cnt #(
  parameter int unsigned LONG_DLY  = 131072,
  parameter int unsigned SHORT_DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic short_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LONG_DLY);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_DLY - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign done_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= short_i ? SHORT_LD : LONG_LD;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0 && !start_i) |=> (active_q && cnt_q == $past(cnt_q) - 1'b1));

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int unsigned LONG_DLY  = 131072,
  parameter int unsigned SHORT_DLY = 16,
  parameter int unsigned CYC_T     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       irq_ni,
  input  logic       rst_wake_ni,
  input  logic       dbg_ni,
  input  logic       short_dly_i,
  output logic       clk_en_o,
  output logic [3:0] stop_cyc_o,
  output logic       decode_block_o,
  output logic       irq_pend_o,
  output logic       resume_o,
  output logic       rst_seq_o
);
  localparam int unsigned TAIL_LEN = 4 * CYC_T + 1;
  localparam int unsigned TW       = $clog2(TAIL_LEN + 1);

  phase_e        phase_q;
  src_e          src_q;
  logic [TW-1:0] tcnt_q;
  logic          pend_q, svc_q, resume_q, rst_q;
  logic [WAKE_N-1:0] pins_n, sync_n;
  logic          any_wake, dly_start, dly_done;

  assign pins_n[W_RST] = rst_wake_ni;
  assign pins_n[W_IRQ] = irq_ni;
  assign pins_n[W_DBG] = dbg_ni;

  wake_sync #(.N(WAKE_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_ni (pins_n),
    .sync_no (sync_n)
  );

  assign any_wake  = ~&sync_n;
  assign dly_start = (phase_q == PH_WAIT) && any_wake;

  stop_dly_cnt #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dly_start),
    .short_i (short_dly_i),
    .done_o  (dly_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_RUN;
      src_q    <= SRC_NONE;
      tcnt_q   <= '0;
      pend_q   <= 1'b0;
      svc_q    <= 1'b0;
      resume_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      pend_q   <= 1'b0;
      resume_q <= 1'b0;
      rst_q    <= 1'b0;
      unique case (phase_q)
        PH_RUN:  if (stop_req_i) phase_q <= PH_EXEC;
        PH_EXEC: phase_q <= PH_WAIT;
        PH_WAIT: if (any_wake) begin
          phase_q <= PH_CNT;
          if      (!sync_n[W_RST]) src_q <= SRC_RST;
          else if (!sync_n[W_IRQ]) src_q <= SRC_IRQ;
          else                     src_q <= SRC_DBG;
        end
        PH_CNT: if (dly_done) begin
          if (src_q == SRC_RST) begin
            phase_q <= PH_RUN;
            rst_q   <= 1'b1;
          end else begin
            phase_q <= PH_TAIL;
            tcnt_q  <= '0;
            pend_q  <= !sync_n[W_IRQ];
            svc_q   <= !sync_n[W_IRQ];
          end
        end
        PH_TAIL: begin
          if (tcnt_q == TW'(TAIL_LEN - 1)) begin
            phase_q  <= PH_RUN;
            resume_q <= !svc_q;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_EXEC: stop_cyc_o = 4'd3;
      PH_WAIT, PH_CNT: stop_cyc_o = 4'd4;
      PH_TAIL: stop_cyc_o = (tcnt_q == '0) ? 4'd4
                          : 4'(5 + (int'(tcnt_q) - 1) / int'(CYC_T));
      default: stop_cyc_o = 4'd0;
    endcase
  end

  assign clk_en_o       = !(phase_q == PH_WAIT || phase_q == PH_CNT);
  assign decode_block_o = (phase_q == PH_EXEC);
  assign irq_pend_o     = pend_q;
  assign resume_o       = resume_q;
  assign rst_seq_o      = rst_q;

  a_r2_exec_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_cyc_o == 4'd3) |=> (stop_cyc_o == 4'd4 && !clk_en_o));

  a_r4_gated_in_c4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (stop_cyc_o == 4'd4));

  a_r1_start_needs_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && &sync_n) |=> (phase_q == PH_WAIT));

  a_r5_pend_in_arb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o |-> (clk_en_o && stop_cyc_o == 4'd4));

  a_r8_excl_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resume_o && rst_seq_o));

  a_r7_resume_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (stop_cyc_o == 4'd0));

  a_r9_cyc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_cyc_o == 4'd0) || (stop_cyc_o >= 4'd3 && stop_cyc_o <= 4'd8));
endmodule

// File: tb/sim_stop_wake_seq.sv
module sim_stop_wake_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic       irq_n = 1'b1, rstw_n = 1'b1, dbg_n = 1'b1;
  logic       sd = 1'b1;
  logic       clk_en, dec_blk, pend, resume, rst_seq;
  logic [3:0] cyc;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stop_wake_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req),
    .irq_ni(irq_n), .rst_wake_ni(rstw_n), .dbg_ni(dbg_n),
    .short_dly_i(sd), .clk_en_o(clk_en), .stop_cyc_o(cyc),
    .decode_block_o(dec_blk), .irq_pend_o(pend),
    .resume_o(resume), .rst_seq_o(rst_seq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // src: 0 reset wake, 1 irq, 2 debug
  task automatic run_seq(input bit short_sel, input int src, input int rel, input bit irq_extra);
    int  len;
    bit  ok;
    bit  exp_pend;
    int  bad;
    len = short_sel ? 16 : 131072;
    sd  = short_sel;
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    check(cyc == 3 && dec_blk && clk_en, "R2 exec cycle", cyc, 3);
    @(negedge clk);
    check(cyc == 4 && !clk_en && !dec_blk, "R2 enter cycle 4", cyc, 4);
    stop_req = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); stop_req = 1'b0;
      if (cyc != 4 || clk_en) ok = 1'b0;
    end
    check(ok, "R1 stretched cycle 4 without wake", cyc, 4);
    case (src)
      0: rstw_n = 1'b0;
      1: irq_n  = 1'b0;
      default: dbg_n = 1'b0;
    endcase
    if (irq_extra) irq_n = 1'b0;
    ok = 1'b1; bad = 0;
    for (int i = 1; i <= len + 2; i++) begin
      @(negedge clk);
      if (cyc != 4 || clk_en) begin ok = 1'b0; bad = i; end
      if (i == 3) sd = !short_sel;
      if (i == rel) begin irq_n = 1'b1; rstw_n = 1'b1; dbg_n = 1'b1; end
    end
    check(ok, "R3 R4 gated for full delay", bad, 0);
    irq_n = 1'b1; rstw_n = 1'b1; dbg_n = 1'b1;
    @(negedge clk);
    if (src == 0) begin
      check(clk_en && cyc == 0, "R8 reset wake skips tail", cyc, 0);
      check(rst_seq && !pend, "R8 reset sequence pulse", rst_seq, 1);
      @(negedge clk);
      check(!rst_seq && !resume && !pend && cyc == 0, "R8 no resume after reset wake", resume, 0);
      return;
    end
    exp_pend = ((src == 1) || irq_extra) && (rel > len);
    check(clk_en && cyc == 4, "R4 clock back at delay end", clk_en, 1);
    check(pend == exp_pend, "R5 pending flag", pend, exp_pend);
    ok = 1'b1; bad = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (cyc != 4'(5 + (i - 1) / 4) || !clk_en || pend || resume) begin ok = 1'b0; bad = i; end
    end
    check(ok, "R6 tail cycles 5 to 8", bad, 0);
    @(negedge clk);
    check(cyc == 0 && clk_en, "R9 back to running", cyc, 0);
    check(resume == !exp_pend && !rst_seq, "R7 resume decision", resume, !exp_pend);
    @(negedge clk);
    check(!resume, "R7 resume is one cycle", resume, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cyc == 0 && clk_en && !dec_blk && !pend && !resume && !rst_seq,
          "R9 reset state", cyc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_seq(1'b1, 1, 16, 1'b0);
    run_seq(1'b1, 1, 17, 1'b0);
    run_seq(1'b1, 2, 2, 1'b0);
    run_seq(1'b1, 2, 20, 1'b1);
    run_seq(1'b1, 0, 2, 1'b0);
    run_seq(1'b1, 0, 20, 1'b1);
    run_seq(1'b1, 1, 1, 1'b0);
    run_seq(1'b0, 2, 5, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule